// File: doc/BRIEF.md
# Port Input Debounce Filter

This block cleans up the raw input levels of an 8-bit general-purpose port before the rest of the chip sees them. Every pin first passes through a two-stage synchronizer. The two lowest pins then go straight to the outputs. Each of the six upper pins has its own filter, which can be switched on or off. A switched-on filter accepts a new level only after it has seen that level on three sampling ticks in a row, so short spikes never reach the output.

One 8-bit control register, written and read through a simple register port, configures the block. Its two top bits select the sampling rate: every clock, every 4 clocks, or every 4096 clocks. The fourth code stops all sampling. The lower six bits enable the filters. When the stop-mode input is high, every filter is bypassed. When stop mode ends, filtering resumes with the stored configuration and no software action is needed.

Top module: `pin_debounce_filter`

## Requirements
- R1: After reset, the control register reads 0x00 and every pin output equals its raw input delayed by the two synchronizer clocks.
- R2: A write (`cfg_we` high at a rising edge) stores `cfg_wdata`, and `cfg_rdata` shows that value from the next cycle on.
- R3: With rate code 00 in bits [7:6], an enabled pin samples on every clock. A new raw level held steady changes the output 5 clocks after it is applied: 2 synchronizer clocks plus 3 sampling ticks.
- R4: On an enabled pin, a raw pulse shorter than 3 sampling ticks never appears at the output. With rate code 00, a pulse of 3 or more clocks appears at the output with the same length.
- R5: Rate code 01 gives a sampling tick every 4 clocks. Any register write restarts the prescaler, so the first tick falls 4 clocks after the write edge. A run of fewer than 3 ticks is rejected.
- R6: Rate code 10 gives a sampling tick every 4096 clocks. A new level applied just after the write is accepted exactly 12288 clocks after the write edge.
- R7: Rate code 11 produces no ticks, so enabled pins hold their last filtered value whatever the raw input does.
- R8: Enable bit n (n = 0..5) controls pin n+2, and a value of 1 turns filtering on. A pin whose bit is 0 outputs its synchronized raw input, 2 clocks after the raw change.
- R9: Pins 0 and 1 are never filtered, and always follow the raw input 2 clocks later.
- R10: While `stop_mode` is high, every pin bypasses its filter. After release, filtering resumes with the stored settings and clean counters, without a register rewrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| stop_mode | input | 1 | Stop-mode indication; high bypasses all filters |
| pin_raw | input | 8 | Asynchronous raw pin levels |
| pin_filt | output | 8 | Synchronized and filtered pin levels |

## Verification
A wrong tick phase or prescaler terminal count shows as an output edge that is early or late by whole sampling periods. At the slowest rate that error appears only after twelve thousand clocks, so the bench measures the exact acceptance cycle at each rate. An agreement counter that is not cleared, or that saturates wrongly, lets short pulses through or shortens long ones. The pulse sweep shows this within about ten clocks as a changed count of high output cycles. A stale filter state around stop mode or an enable change shows at once as a glitch on an output that should be steady.

// File: rtl/pdf_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the port debounce filter.
package pdf_pkg;
   // Sampling-rate codes carried in the top two bits of the control register.
   typedef enum logic [1:0] {
      SEL_EVERY = 2'b00,   // one tick per clock
      SEL_MID   = 2'b01,   // one tick per DIV_MID clocks
      SEL_LONG  = 2'b10,   // one tick per DIV_LONG clocks
      SEL_OFF   = 2'b11    // no ticks at all
   } smp_sel_e;

   localparam int unsigned SEL_W = 2;
endpackage

// File: rtl/pdf_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for asynchronous pin levels.
module pdf_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);
   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
      end else begin
         stg_q[0] <= d_async;
         for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
      end
   end

   assign q_sync = stg_q[STAGES-1];
endmodule

// File: rtl/pdf_cfg_reg.sv
`timescale 1ns/1ps
// Control register: rate select on top, per-pin enables below.
module pdf_cfg_reg #(
   parameter int unsigned REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata;
   end
endmodule

// File: rtl/pdf_tick_gen.sv
`timescale 1ns/1ps
// Sampling-tick prescaler with a restart on every register write.
module pdf_tick_gen
   import pdf_pkg::*;
#(
   parameter int unsigned DIV_MID  = 4,
   parameter int unsigned DIV_LONG = 4096
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      restart,
   input  smp_sel_e  sel,
   output logic      tick
);
   localparam int unsigned CW = (DIV_LONG > 1) ? $clog2(DIV_LONG) : 1;
   localparam logic [CW-1:0] MID_LAST  = CW'(DIV_MID - 1);
   localparam logic [CW-1:0] LONG_LAST = CW'(DIV_LONG - 1);

   logic [CW-1:0] cnt_q;
   logic          tick_c;
   logic          counting;

   always_comb begin
      case (sel)
         SEL_EVERY: tick_c = 1'b1;
         SEL_MID:   tick_c = (cnt_q == MID_LAST);
         SEL_LONG:  tick_c = (cnt_q == LONG_LAST);
         default:   tick_c = 1'b0;
      endcase
   end

   assign counting = (sel == SEL_MID) || (sel == SEL_LONG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cnt_q <= '0;
      else if (restart || tick_c || !counting) cnt_q <= '0;
      else                                   cnt_q <= cnt_q + CW'(1);
   end

   assign tick = tick_c;
endmodule

// File: rtl/pdf_lane.sv
`timescale 1ns/1ps
// One pin's filter: agreement counter plus accepted level.
module pdf_lane #(
   parameter int unsigned HOLD = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic active,
   input  logic s_in,
   output logic f_out
);
   localparam int unsigned CNT_W = (HOLD > 2) ? $clog2(HOLD) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD - 1);

   logic             lvl_q;
   logic [CNT_W-1:0] agree_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q   <= 1'b0;
         agree_q <= '0;
      end else if (!active) begin
         // bypassed: track the input so re-enabling starts clean
         lvl_q   <= s_in;
         agree_q <= '0;
      end else if (tick) begin
         if (s_in != lvl_q) begin
            if (agree_q == LAST) begin
               lvl_q   <= s_in;
               agree_q <= '0;
            end else begin
               agree_q <= agree_q + CNT_W'(1);
            end
         end else begin
            agree_q <= '0;
         end
      end
   end

   assign f_out = active ? lvl_q : s_in;
endmodule

// File: rtl/pin_debounce_filter.sv
`timescale 1ns/1ps
// Port input debounce filter: synchronizer, prescaler, per-pin filters.
module pin_debounce_filter
   import pdf_pkg::*;
#(
   parameter int unsigned PORT_W      = 8,
   parameter int unsigned FILT_LO     = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD        = 3,
   parameter int unsigned DIV_MID     = 4,
   parameter int unsigned DIV_LONG    = 4096,
   localparam int unsigned N_FILT     = PORT_W - FILT_LO,
   localparam int unsigned REG_W      = N_FILT + SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   input  logic              stop_mode,
   input  logic [PORT_W-1:0] pin_raw,
   output logic [PORT_W-1:0] pin_filt
);
   // elaboration-time parameter checks
   if (FILT_LO < 1 || FILT_LO >= PORT_W) begin : g_bad_lo
      $error("FILT_LO must leave at least one plain and one filtered pin");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (HOLD < 2) begin : g_bad_hold
      $error("HOLD must be at least 2");
   end
   if (DIV_MID < 2 || DIV_LONG <= DIV_MID) begin : g_bad_div
      $error("prescaler ratios must satisfy 2 <= DIV_MID < DIV_LONG");
   end

   logic [REG_W-1:0]  cfg_q;
   logic [PORT_W-1:0] sync_q;
   logic [N_FILT-1:0] en;
   smp_sel_e          sel;
   logic              smp_tick;

   pdf_cfg_reg #(.REG_W(REG_W)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .q     (cfg_q)
   );

   assign cfg_rdata = cfg_q;
   assign sel       = smp_sel_e'(cfg_q[REG_W-1 -: SEL_W]);
   assign en        = cfg_q[N_FILT-1:0];

   pdf_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_raw),
      .q_sync  (sync_q)
   );

   pdf_tick_gen #(.DIV_MID(DIV_MID), .DIV_LONG(DIV_LONG)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (cfg_we),
      .sel     (sel),
      .tick    (smp_tick)
   );

   for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      if (i < FILT_LO) begin : g_pass
         assign pin_filt[i] = sync_q[i];
      end else begin : g_filt
         pdf_lane #(.HOLD(HOLD)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (smp_tick),
            .active (en[i-FILT_LO] & ~stop_mode),
            .s_in   (sync_q[i]),
            .f_out  (pin_filt[i])
         );
      end
   end
endmodule

// File: rtl/pdf_checker.sv
`timescale 1ns/1ps
// Port-level properties of the debounce filter, bound to the top.
module pdf_checker #(
   parameter int unsigned PORT_W  = 8,
   parameter int unsigned FILT_LO = 2,
   localparam int unsigned N_FILT = PORT_W - FILT_LO,
   localparam int unsigned REG_W  = N_FILT + 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [REG_W-1:0]  cfg_wdata,
   input logic [REG_W-1:0]  cfg_rdata,
   input logic              stop_mode,
   input logic [PORT_W-1:0] pin_raw,
   input logic [PORT_W-1:0] pin_filt
);
   logic [2:0]        warm_q;   // edges since reset, saturating
   logic [2:0]        quiet_q;  // edges without write or stop change
   logic              stop_q;
   logic [PORT_W-1:0] en_mask;
   logic [PORT_W-1:0] byp_mask;
   logic [PORT_W-1:0] low_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warm_q  <= '0;
         quiet_q <= '0;
         stop_q  <= 1'b0;
      end else begin
         stop_q <= stop_mode;
         if (warm_q != 3'd7) warm_q <= warm_q + 3'd1;
         if (cfg_we || (stop_mode != stop_q)) quiet_q <= '0;
         else if (quiet_q != 3'd7)            quiet_q <= quiet_q + 3'd1;
      end
   end

   assign en_mask  = {cfg_rdata[N_FILT-1:0], {FILT_LO{1'b0}}};
   assign byp_mask = ~en_mask | {PORT_W{stop_mode}};
   assign low_mask = {{N_FILT{1'b0}}, {FILT_LO{1'b1}}};

   // R2: a write shows up on the read port one cycle later
   p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cfg_rdata == $past(cfg_wdata)));

   // R8: disabled (or stopped) pins follow raw input two clocks later
   p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q >= 3'd2) |-> (((pin_filt ^ $past(pin_raw, 2)) & byp_mask) == '0));

   // R9: the low pins are never filtered
   p_low_plain_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q >= 3'd2) |-> (((pin_filt ^ $past(pin_raw, 2)) & low_mask) == '0));

   // R10: stop mode makes the whole port transparent
   p_stop_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_mode && warm_q >= 3'd2) |-> (pin_filt == $past(pin_raw, 2)));

   // R7: with the tick-off code, enabled outputs do not move
   p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q >= 3'd1 && cfg_rdata[REG_W-1 -: 2] == 2'b11 && !stop_mode
       && !$past(stop_mode) && !$past(cfg_we))
      |-> (((pin_filt ^ $past(pin_filt)) & en_mask) == '0));

   // R4: at full rate an enabled output moves only after 3 agreeing raw samples
   p_three_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_q == 3'd7 && cfg_rdata[REG_W-1 -: 2] == 2'b00 && !stop_mode)
      |-> (((($past(pin_raw, 3) ^ pin_filt) | ($past(pin_raw, 4) ^ pin_filt)
            | ($past(pin_raw, 5) ^ pin_filt))
            & (pin_filt ^ $past(pin_filt)) & en_mask) == '0));
endmodule

bind pin_debounce_filter pdf_checker #(.PORT_W(PORT_W), .FILT_LO(FILT_LO)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .stop_mode (stop_mode),
   .pin_raw   (pin_raw),
   .pin_filt  (pin_filt)
);

// File: tb/pin_debounce_filter_test.sv
`timescale 1ns/1ps
module pin_debounce_filter_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic       stop_mode = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] pin_raw = '0;
   logic [7:0] cfg_rdata;
   logic [7:0] pin_filt;
   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   pin_debounce_filter uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .stop_mode (stop_mode),
      .pin_raw   (pin_raw),
      .pin_filt  (pin_filt)
   );

   task automatic step(int n = 1);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] v);
      cfg_wdata = v;
      cfg_we = 1'b1;
      step();
      cfg_we = 1'b0;
   endtask

   // raw high for len sampled edges, returns number of high output cycles
   task automatic pulse(int pin, int len, output int hi);
      hi = 0;
      pin_raw[pin] = 1'b1;
      for (int k = 0; k < len + 15; k++) begin
         step();
         if (k == len - 1) pin_raw[pin] = 1'b0;
         if (pin_filt[pin]) hi++;
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int hi;
      step(3);
      rst_n = 1'b1;
      step();
      // R1: reset state
      chk("R1 cfg after reset", cfg_rdata, 0);
      chk("R1 outputs after reset", pin_filt, 0);
      pin_raw = 8'hA5;
      step(2);
      chk("R1 all pins bypassed", pin_filt, 8'hA5);
      pin_raw = 8'h00;
      step(4);

      // R2: readback
      wr(8'h5A);
      chk("R2 readback 5A", cfg_rdata, 8'h5A);
      wr(8'hC3);
      chk("R2 readback C3", cfg_rdata, 8'hC3);

      // R3: full-rate latency on pin 2 (enables 0x2B -> pins 2,3,5,7)
      wr(8'h2B);
      step(10);
      pin_raw[2] = 1'b1;
      step(4);
      chk("R3 pin2 before third sample", pin_filt[2], 0);
      step(1);
      chk("R3 pin2 after third sample", pin_filt[2], 1);
      pin_raw[2] = 1'b0;
      step(10);

      // R4 / R8: pulse-length sweep on every filterable pin
      for (int pin = 2; pin < 8; pin++) begin
         for (int len = 1; len <= 5; len++) begin
            int en;
            int exp;
            en  = (8'h2B >> (pin - 2)) & 1;
            exp = en ? ((len >= 3) ? len : 0) : len;
            pulse(pin, len, hi);
            if (en) chk($sformatf("R4 pin%0d pulse %0d", pin, len), hi, exp);
            else    chk($sformatf("R8 pin%0d pulse %0d", pin, len), hi, exp);
            step(5);
         end
      end

      // R5: divide-by-4 rate, restart on write
      wr(8'h7F);
      pin_raw[4] = 1'b1;
      step(11);
      chk("R5 pin4 before third tick", pin_filt[4], 0);
      step(1);
      chk("R5 pin4 at third tick", pin_filt[4], 1);
      pin_raw[4] = 1'b0;
      step(6);
      pin_raw[4] = 1'b1;
      begin
         int drops = 0;
         for (int k = 0; k < 20; k++) begin
            step();
            if (!pin_filt[4]) drops++;
         end
         chk("R5 short low run rejected", drops, 0);
      end

      // R6: divide-by-4096 rate
      wr(8'hBF);
      pin_raw[3] = 1'b1;
      step(12287);
      chk("R6 pin3 before third slow tick", pin_filt[3], 0);
      step(1);
      chk("R6 pin3 at third slow tick", pin_filt[3], 1);

      // R7: no ticks, enabled pins hold
      wr(8'hFF);
      pin_raw[5] = 1'b1;
      step(50);
      chk("R7 pin5 held", pin_filt[5], 0);
      // R8: disabling pin5 (bit 3) exposes the synchronized input
      wr(8'hF7);
      chk("R8 pin5 bypass after disable", pin_filt[5], 1);

      // R9: low pins always plain
      pin_raw[1:0] = 2'b11;
      step(1);
      chk("R9 low pins one clock", pin_filt[1:0], 0);
      step(1);
      chk("R9 low pins two clocks", pin_filt[1:0], 3);

      // R10: stop mode bypass and clean resume
      pin_raw = 8'h00;
      wr(8'h3F);
      step(10);
      stop_mode = 1'b1;
      pin_raw[6] = 1'b1;
      step(2);
      chk("R10 pin6 bypassed in stop", pin_filt[6], 1);
      pin_raw[6] = 1'b0;
      step(2);
      chk("R10 pin6 follows low in stop", pin_filt[6], 0);
      stop_mode = 1'b0;
      step(3);
      pulse(6, 2, hi);
      chk("R10 short pulse rejected after stop", hi, 0);
      pulse(6, 4, hi);
      chk("R10 long pulse after stop", hi, 4);
      chk("R10 cfg kept", cfg_rdata, 8'h3F);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule